// File: doc/BRIEF.md
# Serializing Instruction Entry Gate

This block sits at the first stage of the operand execution pipeline. It catches any instruction that is marked as needing serialization and holds it there until the machine is idle. The machine counts as idle when the instruction cache and the data cache are both free of outstanding misses, the push buffer and the write buffer are both empty, and every older instruction has retired. All five of these must be true in the same cycle. While the instruction is held, the gate raises a stall to the front end so that no younger instruction is dispatched. When the conditions are met, the gate emits a one-cycle release pulse to the execute stage.

The gate is a two-state machine. In `GATE_OPEN` it watches arriving instructions. An instruction that does not need serialization passes straight through. A serializing instruction that arrives while the machine is already idle is released in its arrival cycle. A serializing instruction that arrives while the machine is not idle takes the transition *block* into `GATE_HOLD`. In `GATE_HOLD` the stall stays high and the idle test is repeated every cycle. The transition *release* leads back to `GATE_OPEN` in the first cycle that passes the test.

A saturating counter records how many cycles the most recent serializing instruction was held, for performance monitoring. The caches, the buffers and the retirement logic are outside the block.

Top module: `sync_gate`

## Requirements
- R1: After reset, `fe_stall` and `exec_release` are 0 and `wait_count` is 0.
- R2: `exec_release` is high only in a cycle where `ic_busy`=0, `dc_busy`=0, `push_empty`=1, `wbuf_empty`=1 and `older_retired`=1 all hold together.
- R3: A serializing instruction (`instr_valid`=1, `instr_serial`=1) that arrives while all idle conditions hold is released in its arrival cycle, with `fe_stall` low. `wait_count` then reads 0 from the next cycle.
- R4: A serializing instruction that arrives while any idle condition fails raises `fe_stall` combinationally in its arrival cycle. `fe_stall` stays high in every following cycle until the release cycle, and is low in the release cycle itself.
- R5: Each serializing instruction produces exactly one `exec_release` pulse, one cycle long.
- R6: The idle conditions are evaluated again every cycle. Any single one of the five that fails blocks release, even if it held in an earlier cycle.
- R7: After a release, `wait_count` equals the number of cycles from arrival up to, but not including, the release cycle. It keeps that value until the next serializing instruction arrives, which starts a fresh count.
- R8: An instruction with `instr_serial`=0 causes no stall and no release, and leaves `wait_count` unchanged. This holds even when idle conditions fail.
- R9: While in `GATE_HOLD`, `instr_valid` and `instr_serial` are ignored. They produce no extra release and do not disturb the count.
- R10: `wait_count` saturates at 2^CNT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is present at the entry stage |
| instr_serial | input | 1 | Decoded flag: the instruction requires serialization |
| ic_busy | input | 1 | The instruction cache has a miss outstanding |
| dc_busy | input | 1 | The data cache has a miss outstanding |
| push_empty | input | 1 | The push buffer is empty |
| wbuf_empty | input | 1 | The write buffer is empty |
| older_retired | input | 1 | All older instructions have completed |
| fe_stall | output | 1 | Stall to the front end while an instruction is held |
| exec_release | output | 1 | One-cycle pulse that starts execution of the held instruction |
| wait_count | output | CNT_W | Cycles the last serializing instruction was held |

## Verification
Serializing instructions are driven with hold lengths of zero, one, several and more than the counter range. The zero-length case separates a same-cycle release from a one-cycle-late release. The longest hold proves that the counter saturates rather than wraps.

In each long hold the blocking condition rotates among the five inputs, with exactly one failing per cycle. This shows that every input blocks release by itself and that a condition satisfied earlier is not remembered.

Further patterns are:
- Non-serializing instructions presented while the machine is busy, which tell pass-through apart from an unwanted stall.
- New valid instructions presented during a hold, which tell a correctly ignored input apart from a second release.
- Back-to-back zero-wait instructions, which check that the counter clears on each arrival.

// File: rtl/sync_gate_pkg.sv
package sync_gate_pkg;
    typedef enum logic [0:0] {
        GATE_OPEN = 1'b0,
        GATE_HOLD = 1'b1
    } gate_state_t;

    localparam int unsigned N_QUIET = 5;
endpackage

// File: rtl/sync_quiet_detect.sv
module sync_quiet_detect
    import sync_gate_pkg::*;
(
    input  logic [N_QUIET-1:0] cond_ok,
    output logic               all_quiet
);
    logic [N_QUIET:0] chain;

    assign chain[0] = 1'b1;
    for (genvar g = 0; g < N_QUIET; g++) begin : g_and
        assign chain[g+1] = chain[g] & cond_ok[g];
    end
    assign all_quiet = chain[N_QUIET];
endmodule

// File: rtl/sync_gate_fsm.sv
module sync_gate_fsm
    import sync_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic instr_valid,
    input  logic instr_serial,
    input  logic quiet,
    output logic stall,
    output logic release_go,
    output logic arrive,
    output logic arrive_blocked,
    output logic hold_tick
);
    gate_state_t state, state_nx;
    logic        sync_in;

    assign sync_in = instr_valid & instr_serial;

    always_comb begin
        state_nx = state;
        unique case (state)
            GATE_OPEN: if (sync_in && !quiet) state_nx = GATE_HOLD;
            GATE_HOLD: if (quiet)             state_nx = GATE_OPEN;
            default:                          state_nx = GATE_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= GATE_OPEN;
        else        state <= state_nx;
    end

    always_comb begin
        stall          = 1'b0;
        release_go     = 1'b0;
        arrive         = 1'b0;
        arrive_blocked = 1'b0;
        hold_tick      = 1'b0;
        unique case (state)
            GATE_OPEN: begin
                arrive         = sync_in;
                arrive_blocked = sync_in & ~quiet;
                release_go     = sync_in & quiet;
                stall          = sync_in & ~quiet;
            end
            GATE_HOLD: begin
                release_go = quiet;
                stall      = ~quiet;
                hold_tick  = ~quiet;
            end
            default: ;
        endcase
    end

    p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_HOLD && !quiet) |=> (state == GATE_HOLD && (stall || release_go)));
    p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_OPEN && instr_valid && !instr_serial) |-> (!stall && !release_go));
    p_single_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_HOLD && release_go) |=> (state == GATE_OPEN));
    p_no_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && release_go));
endmodule

// File: rtl/sync_wait_counter.sv
module sync_wait_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_blocked,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (start)
            count <= start_blocked ? CNT_W'(1) : '0;
        else if (tick && count != CNT_MAX)
            count <= count + CNT_W'(1);
    end

    p_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && count == CNT_MAX) |=> (count == CNT_MAX));
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !start_blocked) |=> (count == '0));
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && tick && count != CNT_MAX) |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/sync_gate.sv
module sync_gate
    import sync_gate_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic             instr_serial,
    input  logic             ic_busy,
    input  logic             dc_busy,
    input  logic             push_empty,
    input  logic             wbuf_empty,
    input  logic             older_retired,
    output logic             fe_stall,
    output logic             exec_release,
    output logic [CNT_W-1:0] wait_count
);
    logic quiet, arrive, arrive_blocked, hold_tick;

    sync_quiet_detect u_quiet (
        .cond_ok   ({~ic_busy, ~dc_busy, push_empty, wbuf_empty, older_retired}),
        .all_quiet (quiet)
    );

    sync_gate_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .instr_valid    (instr_valid),
        .instr_serial   (instr_serial),
        .quiet          (quiet),
        .stall          (fe_stall),
        .release_go     (exec_release),
        .arrive         (arrive),
        .arrive_blocked (arrive_blocked),
        .hold_tick      (hold_tick)
    );

    sync_wait_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (arrive),
        .start_blocked (arrive_blocked),
        .tick          (hold_tick),
        .count         (wait_count)
    );

    p_go_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_release |-> (!ic_busy && !dc_busy && push_empty && wbuf_empty && older_retired));
endmodule

// File: tb/sim_sync_gate.sv
module sim_sync_gate;
    localparam int CNT_W = 8;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 0, rst_n = 0;
    logic instr_valid = 0, instr_serial = 0;
    logic ic_busy = 0, dc_busy = 0, push_empty = 1, wbuf_empty = 1, older_retired = 1;
    logic fe_stall, exec_release;
    logic [CNT_W-1:0] wait_count;

    int checks = 0, errors = 0;
    int exp_q[$];
    int exp_w = 0;
    bit pending = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sync_gate #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_serial(instr_serial),
        .ic_busy(ic_busy), .dc_busy(dc_busy), .push_empty(push_empty),
        .wbuf_empty(wbuf_empty), .older_retired(older_retired),
        .fe_stall(fe_stall), .exec_release(exec_release), .wait_count(wait_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // k < 0: all idle; k = 0..4 makes exactly one condition fail
    task automatic set_block(input int k);
        ic_busy       = (k == 0);
        dc_busy       = (k == 1);
        push_empty    = (k != 2);
        wbuf_empty    = (k != 3);
        older_retired = (k != 4);
    endtask

    // Monitor: pops the expected hold length for each release and compares the counter one cycle later
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (pending) begin
                chk("R7 wait_count after release", int'(wait_count), exp_w);
                pending = 0;
            end
            if (exec_release) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R5: actual unexpected release expected none at %0t", $time);
                end else begin
                    exp_w = exp_q.pop_front();
                    pending = 1;
                end
            end
        end
    end

    // Driver: one serializing instruction held for n cycles, blocker rotating from blk
    task automatic sync_instr(input int n, input int blk, input bit junk);
        @(negedge clk);
        instr_valid = 1; instr_serial = 1;
        set_block(n > 0 ? blk : -1);
        exp_q.push_back(n > CMAX ? CMAX : n);
        #1;
        chk("R4/R3 stall at arrival", int'(fe_stall), n > 0 ? 1 : 0);
        chk("R3 release at arrival", int'(exec_release), n == 0 ? 1 : 0);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            instr_valid = junk; instr_serial = junk;
            set_block(i < n ? (blk + i) % 5 : -1);
            #1;
            if (i < n) begin
                chk("R4 R6 stall while held", int'(fe_stall), 1);
                chk("R6 R9 no early release", int'(exec_release), 0);
            end else begin
                chk("R4 stall low at release", int'(fe_stall), 0);
                chk("R2 release when idle", int'(exec_release), 1);
            end
        end
        @(negedge clk);
        instr_valid = 0; instr_serial = 0; set_block(-1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 stall after reset", int'(fe_stall), 0);
        chk("R1 release after reset", int'(exec_release), 0);
        chk("R1 count after reset", int'(wait_count), 0);
        @(negedge clk); rst_n = 1;

        sync_instr(0, 0, 0);
        sync_instr(1, 0, 0);
        sync_instr(5, 1, 0);
        sync_instr(7, 2, 1);      // R9: valid serializing junk during hold
        sync_instr(0, 0, 0);      // R7: fresh count clears to 0
        sync_instr(10, 4, 1);
        sync_instr(0, 0, 0);
        sync_instr(0, 0, 0);      // back-to-back zero-wait arrivals
        sync_instr(3, 3, 0);

        // R8: non-serializing instructions while busy
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            instr_valid = 1; instr_serial = 0; set_block(k);
            #1;
            chk("R8 no stall for plain instr", int'(fe_stall), 0);
            chk("R8 no release for plain instr", int'(exec_release), 0);
        end
        @(negedge clk);
        instr_valid = 0; set_block(-1);
        #1;
        chk("R8 count unchanged", int'(wait_count), 3);

        sync_instr(300, 0, 0);    // R10 saturation
        repeat (3) @(negedge clk);
        #3;
        chk("R10 count saturated", int'(wait_count), CMAX);
        chk("R5 all releases seen", exp_q.size(), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule